// File: doc/BRIEF.md
# Nonvolatile Transfer Sequencer

This block moves data between a small volatile word array and its nonvolatile shadow. A store copies the volatile words into the shadow. It runs in two phases: an erase phase wipes the shadow, and then a program phase writes the shadow one word per cycle. A recall copies the shadow back into the volatile array. It also has two phases: a clear phase zeroes the volatile array, and then a copy phase fills it one word per cycle. A recall only reads the shadow and never changes it.

Store requests come from a hardware request line and from a software command line. Recall requests come from a software command line and from supply monitoring. Two comparator flags describe the supply. One reports that the supply is below the reset level. The other reports that the supply is above the switch level.

- A low-supply report, and also reset itself, sets an internal power recall flag.
- While that flag is set, host access stays disabled.
- The recall launches by itself once the supply is above the switch level and no longer below the reset level.

While any transfer runs, or while the power recall is still pending, the host word port is shut. Host writes are dropped and host read data holds its value. A one-cycle done pulse marks the end of every transfer, so that a request controller can release its busy drive and clear its dirty flag.

The controller has five states:

| State | What it does | Leaves when the phase counter expires, for |
|---|---|---|
| `ST_IDLE` | Waits for a request | — |
| `ST_ERASE` | Wipes the shadow on its last cycle | `ST_PROGRAM` |
| `ST_PROGRAM` | Copies one volatile word into the shadow per cycle | `ST_IDLE`, with done |
| `ST_CLEAR` | Zeroes the volatile array on its last cycle | `ST_COPY` |
| `ST_COPY` | Copies one shadow word into the volatile array per cycle | `ST_IDLE`, with done |

From `ST_IDLE` there are three ways out:
- launch power recall, to `ST_CLEAR`;
- launch store, to `ST_ERASE`;
- launch software recall, to `ST_CLEAR`.

Top module: `nv_xfer_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `io_disable` is 1. No transfer starts while `vcc_above_switch` stays 0.
- R2: A cycle with `vcc_below_reset`=1 sets a pending power recall and holds `io_disable` at 1, and nothing starts in that cycle. Once `vcc_above_switch`=1 and `vcc_below_reset`=0, a recall starts on the next clock edge.
- R3: A store holds `busy` for exactly ERASE_CYC+DEPTH cycles (default 14). Afterwards the shadow equals the volatile array as it stood when the store began.
- R4: A recall holds `busy` for exactly CLEAR_CYC+DEPTH cycles (default 11). Afterwards every volatile word equals the corresponding shadow word.
- R5: A recall leaves the shadow unchanged, so repeated recalls always return the last stored data.
- R6: While `io_disable`=1, host writes (`host_en`=1, `host_we`=1) do not change the array, and host reads leave `host_rdata` unchanged. With `io_disable`=0, a read presents `host_rdata` one cycle after the request.
- R7: Requests that arrive while `busy`=1 are ignored. They neither lengthen the running transfer nor start another after it.
- R8: Launch priority is pending power recall first, then store (`hw_store_req` or `sw_store_req`), then `sw_recall_req`. Store and software recall requests are ignored while a power recall is pending.
- R9: `done` is 1 for exactly one cycle: the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also marks a power recall as pending |
| hw_store_req | input | 1 | Store request from the hardware request controller |
| sw_store_req | input | 1 | Store request from the software command detector |
| sw_recall_req | input | 1 | Recall request from the software command detector |
| vcc_below_reset | input | 1 | Comparator: supply below the reset level |
| vcc_above_switch | input | 1 | Comparator: supply above the switch level |
| host_en | input | 1 | Host word access enable |
| host_we | input | 1 | Host access is a write when 1 |
| host_addr | input | AW | Host word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| busy | output | 1 | A store or recall is running |
| io_disable | output | 1 | Host port shut (busy or power recall pending) |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
On every cycle, the assertions check the following:
- a running transfer keeps the host port shut;
- read data holds while the port is shut;
- a low-supply cycle both shuts the port and blocks a launch;
- the done pulse is one cycle long and follows busy falling;
- each busy run has one of the two legal lengths.

Only the bench scenarios can show that the data is right:
- a store snapshots the volatile words;
- a recall restores them and leaves the shadow intact;
- dropped writes really are dropped;
- simultaneous requests resolve in priority order.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ERASE   = 3'd1,
        ST_PROGRAM = 3'd2,
        ST_CLEAR   = 3'd3,
        ST_COPY    = 3'd4
    } xfer_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/nv_word_array.sv
module nv_word_array #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[w] <= '0;
            end else if (clr) begin
                words[w] <= '0;
            end else if (we && (waddr == AW'(w))) begin
                words[w] <= wdata;
            end
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/nv_xfer_fsm.sv
module nv_xfer_fsm
    import nv_xfer_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int ERASE_CYC = 6,
    parameter int CLEAR_CYC = 3,
    parameter int DEPTH     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_store_req,
    input  logic             sw_store_req,
    input  logic             sw_recall_req,
    input  logic             vcc_below_reset,
    input  logic             vcc_above_switch,
    input  logic             phase_last,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             nv_clear,
    output logic             sram_clear,
    output logic             nv_we,
    output logic             sram_copy_we,
    output logic             busy,
    output logic             io_disable,
    output logic             done
);

    localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] CLEAR_LAST = CNT_W'(CLEAR_CYC - 1);
    localparam logic [CNT_W-1:0] WORD_LAST  = CNT_W'(DEPTH - 1);

    xfer_state_e state_q, state_d;
    logic        pend_q;
    logic        done_q;
    logic        finish;
    logic        supply_ok;
    logic        pwr_go;
    logic        store_go;
    logic        recall_go;

    // Launch decisions: pending power recall wins and blocks the others.
    always_comb begin
        supply_ok = vcc_above_switch && !vcc_below_reset;
        pwr_go    = pend_q && supply_ok;
        store_go  = !pend_q && !vcc_below_reset && (hw_store_req || sw_store_req);
        recall_go = !pend_q && !vcc_below_reset && sw_recall_req;
    end

    // Next-state and phase-timer loading.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pwr_go) begin
                    state_d  = ST_CLEAR;
                    tmr_load = 1'b1;
                    tmr_val  = CLEAR_LAST;
                end else if (store_go) begin
                    state_d  = ST_ERASE;
                    tmr_load = 1'b1;
                    tmr_val  = ERASE_LAST;
                end else if (recall_go) begin
                    state_d  = ST_CLEAR;
                    tmr_load = 1'b1;
                    tmr_val  = CLEAR_LAST;
                end
            end
            ST_ERASE: begin
                if (phase_last) begin
                    state_d  = ST_PROGRAM;
                    tmr_load = 1'b1;
                    tmr_val  = WORD_LAST;
                end
            end
            ST_PROGRAM: begin
                if (phase_last) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            ST_CLEAR: begin
                if (phase_last) begin
                    state_d  = ST_COPY;
                    tmr_load = 1'b1;
                    tmr_val  = WORD_LAST;
                end
            end
            ST_COPY: begin
                if (phase_last) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, pending power recall flag and done pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (vcc_below_reset) begin
                pend_q <= 1'b1;
            end else if (state_q == ST_IDLE && pwr_go) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Outputs decoded from state.
    always_comb begin
        busy         = (state_q != ST_IDLE);
        io_disable   = busy || pend_q;
        nv_clear     = (state_q == ST_ERASE) && phase_last;
        sram_clear   = (state_q == ST_CLEAR) && phase_last;
        nv_we        = (state_q == ST_PROGRAM);
        sram_copy_we = (state_q == ST_COPY);
        done         = done_q;
    end

endmodule

// File: rtl/nv_xfer_engine.sv
module nv_xfer_engine
    import nv_xfer_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 8,
    parameter int ERASE_CYC = 6,
    parameter int CLEAR_CYC = 3,
    parameter int AW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_store_req,
    input  logic              sw_store_req,
    input  logic              sw_recall_req,
    input  logic              vcc_below_reset,
    input  logic              vcc_above_switch,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic              io_disable,
    output logic              done
);

    localparam int MAX_LEN = max3(ERASE_CYC, CLEAR_CYC, DEPTH);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic [CNT_W-1:0]  tmr_cnt;
    logic              tmr_last;
    logic              nv_clear;
    logic              sram_clear;
    logic              nv_we;
    logic              sram_copy_we;
    logic [AW-1:0]     word_idx;
    logic              host_wr_ok;
    logic              sram_we;
    logic [AW-1:0]     sram_waddr;
    logic [DATA_W-1:0] sram_wdata;
    logic [AW-1:0]     sram_raddr;
    logic [DATA_W-1:0] sram_rd;
    logic [DATA_W-1:0] nv_rd;

    nv_xfer_fsm #(
        .CNT_W     (CNT_W),
        .ERASE_CYC (ERASE_CYC),
        .CLEAR_CYC (CLEAR_CYC),
        .DEPTH     (DEPTH)
    ) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .hw_store_req     (hw_store_req),
        .sw_store_req     (sw_store_req),
        .sw_recall_req    (sw_recall_req),
        .vcc_below_reset  (vcc_below_reset),
        .vcc_above_switch (vcc_above_switch),
        .phase_last       (tmr_last),
        .tmr_load         (tmr_load),
        .tmr_val          (tmr_val),
        .nv_clear         (nv_clear),
        .sram_clear       (sram_clear),
        .nv_we            (nv_we),
        .sram_copy_we     (sram_copy_we),
        .busy             (busy),
        .io_disable       (io_disable),
        .done             (done)
    );

    nv_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .last     (tmr_last)
    );

    // Word moves walk the addresses downward with the phase counter.
    assign word_idx   = tmr_cnt[AW-1:0];
    assign host_wr_ok = host_en && host_we && !io_disable;
    assign sram_we    = sram_copy_we || host_wr_ok;
    assign sram_waddr = sram_copy_we ? word_idx : host_addr;
    assign sram_wdata = sram_copy_we ? nv_rd : host_wdata;
    assign sram_raddr = busy ? word_idx : host_addr;

    nv_word_array #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .AW     (AW)
    ) u_sram (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sram_clear),
        .we    (sram_we),
        .waddr (sram_waddr),
        .wdata (sram_wdata),
        .raddr (sram_raddr),
        .rdata (sram_rd)
    );

    nv_word_array #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .AW     (AW)
    ) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (nv_clear),
        .we    (nv_we),
        .waddr (word_idx),
        .wdata (sram_rd),
        .raddr (word_idx),
        .rdata (nv_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_en && !host_we && !io_disable) begin
            host_rdata <= sram_rd;
        end
    end

endmodule

// File: rtl/nv_xfer_checker.sv
module nv_xfer_checker #(
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 8,
    parameter int ERASE_CYC = 6,
    parameter int CLEAR_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vcc_below_reset,
    input logic              host_en,
    input logic [DATA_W-1:0] host_rdata,
    input logic              busy,
    input logic              io_disable,
    input logic              done
);

    localparam int STORE_LEN  = ERASE_CYC + DEPTH;
    localparam int RECALL_LEN = CLEAR_CYC + DEPTH;

    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 16'd1;
        end else begin
            run_q <= '0;
        end
    end

    AST_BUSY_SHUTS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> io_disable); // R6

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_disable && host_en) |=> $stable(host_rdata)); // R6

    AST_LOW_SUPPLY_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_below_reset |=> io_disable); // R2

    AST_LOW_SUPPLY_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_below_reset && !busy) |=> !busy); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 16'(STORE_LEN > RECALL_LEN ? STORE_LEN : RECALL_LEN)); // R3

    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_q != '0) |-> (run_q == 16'(STORE_LEN) || run_q == 16'(RECALL_LEN))); // R4

endmodule

bind nv_xfer_engine nv_xfer_checker #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .ERASE_CYC (ERASE_CYC),
    .CLEAR_CYC (CLEAR_CYC)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .vcc_below_reset (vcc_below_reset),
    .host_en         (host_en),
    .host_rdata      (host_rdata),
    .busy            (busy),
    .io_disable      (io_disable),
    .done            (done)
);

// File: tb/tb_nv_xfer_engine.sv
module tb_nv_xfer_engine;

    localparam int DATA_W    = 8;
    localparam int DEPTH     = 8;
    localparam int ERASE_CYC = 6;
    localparam int CLEAR_CYC = 3;
    localparam int AW        = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hw_store_req = 1'b0;
    logic              sw_store_req = 1'b0;
    logic              sw_recall_req = 1'b0;
    logic              vcc_below_reset = 1'b0;
    logic              vcc_above_switch = 1'b0;
    logic              host_en = 1'b0;
    logic              host_we = 1'b0;
    logic [AW-1:0]     host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic              busy;
    logic              io_disable;
    logic              done;

    int n_checks = 0;
    int n_errors = 0;
    logic [DATA_W-1:0] exp_sram [DEPTH];
    logic [DATA_W-1:0] exp_nv   [DEPTH];

    always #5 clk = ~clk;

    nv_xfer_engine #(
        .DATA_W    (DATA_W),
        .DEPTH     (DEPTH),
        .ERASE_CYC (ERASE_CYC),
        .CLEAR_CYC (CLEAR_CYC)
    ) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .hw_store_req     (hw_store_req),
        .sw_store_req     (sw_store_req),
        .sw_recall_req    (sw_recall_req),
        .vcc_below_reset  (vcc_below_reset),
        .vcc_above_switch (vcc_above_switch),
        .host_en          (host_en),
        .host_we          (host_we),
        .host_addr        (host_addr),
        .host_wdata       (host_wdata),
        .host_rdata       (host_rdata),
        .busy             (busy),
        .io_disable       (io_disable),
        .done             (done)
    );

    function automatic int store_len();
        return ERASE_CYC + DEPTH;
    endfunction

    function automatic int recall_len();
        return CLEAR_CYC + DEPTH;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input int d);
        host_en    = 1'b1;
        host_we    = 1'b1;
        host_addr  = AW'(a);
        host_wdata = DATA_W'(d);
        if (!io_disable) exp_sram[a] = DATA_W'(d);
        @(negedge clk);
        host_en = 1'b0;
        host_we = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [DATA_W-1:0] d);
        host_en   = 1'b1;
        host_we   = 1'b0;
        host_addr = AW'(a);
        @(negedge clk);
        d       = host_rdata;
        host_en = 1'b0;
    endtask

    task automatic verify_all(input string req);
        logic [DATA_W-1:0] d;
        for (int a = 0; a < DEPTH; a++) begin
            host_read(a, d);
            check(d == exp_sram[a], req, int'(d), int'(exp_sram[a]));
        end
    endtask

    // kind: 0 store, 1 recall
    task automatic run_op(input logic hs, input logic ss, input logic sr,
                          input int kind, input string req);
        int len;
        int exp_len;
        hw_store_req  = hs;
        sw_store_req  = ss;
        sw_recall_req = sr;
        @(negedge clk);
        hw_store_req  = 1'b0;
        sw_store_req  = 1'b0;
        sw_recall_req = 1'b0;
        len = 0;
        while (busy && len < 200) begin
            len++;
            @(negedge clk);
        end
        exp_len = (kind == 0) ? store_len() : recall_len();
        check(len == exp_len, req, len, exp_len);
        check(done == 1'b1, "R9 done after op", int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R9 done single", int'(done), 0);
        if (kind == 0) begin
            for (int a = 0; a < DEPTH; a++) exp_nv[a] = exp_sram[a];
        end else begin
            for (int a = 0; a < DEPTH; a++) exp_sram[a] = exp_nv[a];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] prev;
        int cnt;
        void'($urandom(32'd20240611));
        for (int a = 0; a < DEPTH; a++) begin
            exp_sram[a] = '0;
            exp_nv[a]   = '0;
        end

        // R1: reset state and no launch without supply
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(io_disable == 1'b1, "R1 io_disable after reset", int'(io_disable), 1);
        hw_store_req = 1'b1;
        repeat (4) @(negedge clk);
        hw_store_req = 1'b0;
        check(busy == 1'b0, "R1 no launch before switch level", int'(busy), 0);
        host_write(0, 8'hAA); // dropped: port still shut (R6)

        // R2: supply recovery launches the pending recall
        vcc_above_switch = 1'b1;
        run_op(1'b0, 1'b0, 1'b0, 1, "R2 power recall length");
        check(io_disable == 1'b0, "R2 port open after recall", int'(io_disable), 0);
        verify_all("R6 write while pending dropped");

        // Random mix of writes, stores and recalls (R3, R4)
        for (int it = 0; it < 24; it++) begin
            int op;
            for (int k = 0; k < 3; k++) host_write(int'($urandom % DEPTH), int'($urandom % 256));
            op = int'($urandom % 3);
            if (op == 0) run_op(1'b1, 1'b0, 1'b0, 0, "R3 hw store length");
            else if (op == 1) run_op(1'b0, 1'b1, 1'b0, 0, "R3 sw store length");
            else begin
                run_op(1'b0, 1'b0, 1'b1, 1, "R4 recall length");
                verify_all("R4 recall data");
            end
        end

        // R5: repeated recalls return the last stored data
        for (int a = 0; a < DEPTH; a++) host_write(a, 16 + a * 7);
        run_op(1'b1, 1'b0, 1'b0, 0, "R3 store length");
        for (int a = 0; a < DEPTH; a++) host_write(a, 200 - a);
        run_op(1'b0, 1'b0, 1'b1, 1, "R5 recall length");
        verify_all("R5 first recall");
        for (int a = 0; a < DEPTH; a++) host_write(a, 99 + a);
        run_op(1'b0, 1'b0, 1'b1, 1, "R5 recall length");
        verify_all("R5 second recall");

        // R6, R7: accesses and requests during a store
        host_read(3, prev);
        hw_store_req = 1'b1;
        @(negedge clk);
        hw_store_req = 1'b0;
        cnt = 0;
        while (busy && cnt < 200) begin
            if (cnt == 1) begin
                host_en = 1'b1; host_we = 1'b1; host_addr = 3'd1;
                host_wdata = ~exp_sram[1];
                sw_recall_req = 1'b1;
                sw_store_req  = 1'b1;
            end else if (cnt == 2) begin
                sw_recall_req = 1'b0;
                sw_store_req  = 1'b0;
                host_we = 1'b0; host_addr = 3'd2;
            end else if (cnt == 3) begin
                check(host_rdata == prev, "R6 rdata held while busy",
                      int'(host_rdata), int'(prev));
                host_en = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        check(cnt == store_len(), "R7 store not lengthened", cnt, store_len());
        for (int a = 0; a < DEPTH; a++) exp_nv[a] = exp_sram[a];
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R7 no queued transfer", int'(busy), 0);
        verify_all("R6 busy write dropped");

        // R8: pending power recall beats a simultaneous store
        for (int a = 0; a < DEPTH; a++) host_write(a, 50 + a);
        vcc_above_switch = 1'b0;
        vcc_below_reset  = 1'b1;
        @(negedge clk);
        check(io_disable == 1'b1, "R2 low supply shuts port", int'(io_disable), 1);
        check(busy == 1'b0, "R2 no launch on low supply", int'(busy), 0);
        vcc_below_reset  = 1'b0;
        vcc_above_switch = 1'b1;
        run_op(1'b1, 1'b0, 1'b0, 1, "R8 power recall wins length");
        verify_all("R8 power recall wins data");

        // R8: store beats software recall
        for (int a = 0; a < DEPTH; a++) host_write(a, 120 + a);
        run_op(1'b0, 1'b1, 1'b1, 0, "R8 store over recall length");
        for (int a = 0; a < DEPTH; a++) host_write(a, 0);
        run_op(1'b0, 1'b0, 1'b1, 1, "R4 recall length");
        verify_all("R8 store data kept");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule